// File: doc/BRIEF.md
# I2C Master Clock and Bit-Count Controller

This block produces the serial clock of an I2C bus master and keeps count of the bits in each byte-sized transfer. A 3-bit rate code selects an exponent n. The master holds the clock line low for 2^n system-clock cycles. It then releases the line and counts a high phase of 2^n + 8 cycles. That count begins only once the synchronized line is seen high, so any other device that holds the wired-AND line low stretches the clock.

A 3-bit length field chooses how many data bits the next transfer carries. An optional acknowledge clock can be added after the data bits. Any start condition on the bus resets the length field, so address bytes always carry eight bits. When the block is not the master, it counts the clock pulses of another master instead. Short pulses are filtered out, and the block reports each counted clock and the end of each byte.

Top module: `i2c_sclk_ctrl`

## Requirements
- R1: In master mode, each clock low phase holds `scl_pull_low` high for exactly 2^(code+4) system-clock cycles, for rate codes 0 to 6.
- R2: The high phase counts 2^n + 8 cycles from the moment the two-flop synchronized SCL is seen high. With nobody else holding the line, `scl_pull_low` therefore stays low for 2^n + 11 cycles per clock.
- R3: Rate code 7 is not a valid setting and is treated as code 6, giving n = 10.
- R4: While the synchronized SCL is low, the high-phase count is held. Each extra cycle that another device keeps the line low lengthens the released interval by one cycle.
- R5: Length field value 0 selects 8 data clocks; values 1 to 7 select that many data clocks.
- R6: With `ack_en` high, one extra clock follows the data clocks and is counted in the byte. With `ack_en` low, no extra clock is generated in master mode.
- R7: `byte_done` pulses for exactly one cycle, in the cycle where the last high phase ends. The master then keeps SCL pulled low until the next `go`.
- R8: `start_seen` pulses once when SDA falls while the filtered SCL is high. An SDA fall while SCL is low is not a start.
- R9: A start condition clears the length field to 0. Otherwise the field keeps the last value written through `cnt_we`/`cnt_wdata`.
- R10: In slave mode (`master_en` low), each filtered SCL rising edge gives one `bit_tick`. `byte_done` pulses at the falling edge after the last counted clock. With `ack_en` low, the following clock starts the next byte.
- R11: SCL levels lasting fewer than 16 system-clock cycles are ignored by slave-mode counting.
- R12: A start condition in slave mode restarts the bit count of the current byte.
- R13: After reset the line is released, `bit_tick`, `byte_done` and `start_seen` are low, and the length field reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | 1: generate the clock; 0: count another master's clock |
| go | input | 1 | Begin one byte transfer in master mode |
| rate_code | input | 3 | Clock rate select, n = code + 4 |
| ack_en | input | 1 | Add an acknowledge clock to each byte |
| cnt_we | input | 1 | Write strobe for the length field |
| cnt_wdata | input | 3 | New length field value |
| scl_in | input | 1 | Sensed level of the wired-AND SCL line |
| sda_in | input | 1 | Sensed level of SDA, used for start detection |
| scl_pull_low | output | 1 | 1 pulls SCL low; 0 releases it |
| bit_tick | output | 1 | One-cycle pulse per counted clock |
| byte_done | output | 1 | One-cycle pulse at the end of a byte |
| start_seen | output | 1 | One-cycle pulse on a detected start condition |
| cnt_field | output | 3 | Current length field value |

## Verification
Master bytes are run at every rate code, including the invalid code 7, to tell the low and high phase lengths apart and to show that code 7 maps to 6. Byte lengths of 1, 3 and 8, with and without the acknowledge clock, check the clock count per byte. One run holds the line low beyond the release point to show the stretched high phase. In slave mode, pulse trains check counting, the acknowledge clock and the start of the next byte. A short glitch and an SDA fall while SCL is low must leave no trace, and a start in the middle of a byte must restart the count.

// File: rtl/i2c_sclk_pkg.sv
package i2c_sclk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HWAIT,
        ST_HIGH,
        ST_PARK
    } mst_state_e;

endpackage

// File: rtl/i2c_sclk_rate.sv
module i2c_sclk_rate #(
    parameter int RATE_W     = 3,
    parameter int MIN_EXP    = 4,
    parameter int HIGH_EXTRA = 8,
    parameter int TMR_W      = 11
) (
    input  logic [RATE_W-1:0] rate_code,
    output logic [TMR_W-1:0]  low_len,
    output logic [TMR_W-1:0]  high_len
);
    localparam int N_CODE   = 2 ** RATE_W;
    localparam int TOP_CODE = N_CODE - 2;

    logic [TMR_W-1:0] len_tbl [N_CODE];

    // codes above the last valid one fold onto it
    for (genvar g = 0; g < N_CODE; g++) begin : g_len
        localparam int EXP = MIN_EXP + ((g > TOP_CODE) ? TOP_CODE : g);
        assign len_tbl[g] = TMR_W'(2 ** EXP);
    end

    assign low_len  = len_tbl[rate_code];
    assign high_len = len_tbl[rate_code] + TMR_W'(HIGH_EXTRA);

endmodule

// File: rtl/i2c_sclk_sync.sv
module i2c_sclk_sync #(
    parameter int GLITCH_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pin,
    input  logic sda_pin,
    output logic scl_sync,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_pulse
);
    localparam int GW = $clog2(GLITCH_CYC + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          d1;
        logic          d2;
        logic          d3;
        logic          filt;
        logic [GW-1:0] gcnt;
        logic          rise;
        logic          fall;
        logic          start;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.s1   = scl_pin;
        d.s2   = q.s1;
        d.d1   = sda_pin;
        d.d2   = q.d1;
        d.d3   = q.d2;
        d.rise = 1'b0;
        d.fall = 1'b0;
        if (q.s2 == q.filt) begin
            d.gcnt = '0;
        end else if (q.gcnt == GW'(GLITCH_CYC - 1)) begin
            d.gcnt = '0;
            d.filt = q.s2;
            d.rise = q.s2;
            d.fall = ~q.s2;
        end else begin
            d.gcnt = q.gcnt + GW'(1);
        end
        d.start = q.filt & q.d3 & ~q.d2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, 1'b0, 1'b0, 1'b0};
        end else begin
            q <= d;
        end
    end

    assign scl_sync    = q.s2;
    assign scl_rise    = q.rise;
    assign scl_fall    = q.fall;
    assign start_pulse = q.start;

    AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        q.rise |=> !q.fall); // R11

endmodule

// File: rtl/i2c_sclk_count.sv
module i2c_sclk_count #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             start_clr,
    input  logic             ack_en,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cfg_q,
    output logic             all_done
);
    localparam int FULL = 2 ** CNT_W;
    localparam int CW   = $clog2(FULL + 2);

    logic [CNT_W-1:0] cfg_d;
    logic [CW-1:0]    done_d, done_q;
    logic [CW-1:0]    data_bits, total;

    assign data_bits = (cfg_q == '0) ? CW'(FULL) : CW'(cfg_q);
    assign total     = data_bits + CW'(ack_en);
    assign all_done  = (done_q >= total);

    always_comb begin
        cfg_d  = cfg_q;
        done_d = done_q;
        if (start_clr) begin
            cfg_d = '0;
        end else if (cfg_we) begin
            cfg_d = cfg_wdata;
        end
        if (clr) begin
            done_d = '0;
        end else if (inc) begin
            done_d = done_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            done_q <= '0;
        end else begin
            cfg_q  <= cfg_d;
            done_q <= done_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && !clr && done_q == '1)); // R5

endmodule

// File: rtl/i2c_sclk_ctrl.sv
module i2c_sclk_ctrl
    import i2c_sclk_pkg::*;
#(
    parameter int RATE_W     = 3,
    parameter int CNT_W      = 3,
    parameter int MIN_EXP    = 4,
    parameter int HIGH_EXTRA = 8,
    parameter int GLITCH_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_en,
    input  logic              go,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              ack_en,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull_low,
    output logic              bit_tick,
    output logic              byte_done,
    output logic              start_seen,
    output logic [CNT_W-1:0]  cnt_field
);
    localparam int TOP_CODE = 2 ** RATE_W - 2;
    localparam int MAX_EXP  = MIN_EXP + TOP_CODE;
    localparam int TMR_W    = $clog2(2 ** MAX_EXP + HIGH_EXTRA + 1);

    typedef struct packed {
        mst_state_e       st;
        logic [TMR_W-1:0] tmr;
        logic             drv;
        logic             tick;
        logic             done;
    } ctl_t;

    ctl_t q, d;

    logic [TMR_W-1:0] low_len, high_len;
    logic scl_sync, scl_rise, scl_fall;
    logic inc, clr, all_done;

    i2c_sclk_rate #(
        .RATE_W    (RATE_W),
        .MIN_EXP   (MIN_EXP),
        .HIGH_EXTRA(HIGH_EXTRA),
        .TMR_W     (TMR_W)
    ) u_rate (
        .rate_code(rate_code),
        .low_len  (low_len),
        .high_len (high_len)
    );

    i2c_sclk_sync #(
        .GLITCH_CYC(GLITCH_CYC)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_pin    (scl_in),
        .sda_pin    (sda_in),
        .scl_sync   (scl_sync),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_pulse(start_seen)
    );

    i2c_sclk_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cnt_we),
        .cfg_wdata(cnt_wdata),
        .start_clr(start_seen),
        .ack_en   (ack_en),
        .inc      (inc),
        .clr      (clr),
        .cfg_q    (cnt_field),
        .all_done (all_done)
    );

    always_comb begin
        d      = q;
        d.tick = 1'b0;
        d.done = 1'b0;
        inc    = 1'b0;
        clr    = 1'b0;
        if (!master_en) begin
            // follower: count another master's filtered clock
            d.st  = ST_IDLE;
            d.drv = 1'b0;
            d.tmr = '0;
            if (scl_rise) begin
                d.tick = 1'b1;
                inc    = 1'b1;
            end
            if (scl_fall && all_done) begin
                d.done = 1'b1;
                clr    = 1'b1;
            end
            if (start_seen) begin
                clr = 1'b1;
            end
        end else begin
            unique case (q.st)
                ST_IDLE, ST_PARK: begin
                    if (go) begin
                        d.st  = ST_LOW;
                        d.drv = 1'b1;
                        d.tmr = low_len - TMR_W'(1);
                        clr   = 1'b1;
                    end
                end
                ST_LOW: begin
                    if (q.tmr == '0) begin
                        d.st  = ST_HWAIT;
                        d.drv = 1'b0;
                    end else begin
                        d.tmr = q.tmr - TMR_W'(1);
                    end
                end
                ST_HWAIT: begin
                    if (scl_sync) begin
                        d.st   = ST_HIGH;
                        d.tmr  = high_len - TMR_W'(1);
                        d.tick = 1'b1;
                        inc    = 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (scl_sync) begin
                        if (q.tmr == '0) begin
                            d.drv = 1'b1;
                            if (all_done) begin
                                d.st   = ST_PARK;
                                d.done = 1'b1;
                                clr    = 1'b1;
                            end else begin
                                d.st  = ST_LOW;
                                d.tmr = low_len - TMR_W'(1);
                            end
                        end else begin
                            d.tmr = q.tmr - TMR_W'(1);
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ST_IDLE, '0, 1'b0, 1'b0, 1'b0};
        end else begin
            q <= d;
        end
    end

    assign scl_pull_low = q.drv;
    assign bit_tick     = q.tick;
    assign byte_done    = q.done;

    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && q.st == ST_HIGH && !scl_sync) |=> ($stable(q.tmr) || !master_en)); // R4
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> (cnt_field == '0)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done); // R7
    AST_TICK_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_tick && byte_done)); // R10

endmodule

// File: tb/sim_i2c_sclk_ctrl.sv
module sim_i2c_sclk_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_en = 1'b0;
    logic       go = 1'b0;
    logic [2:0] rate_code = '0;
    logic       ack_en = 1'b0;
    logic       cnt_we = 1'b0;
    logic [2:0] cnt_wdata = '0;
    logic       ext_low = 1'b0;
    logic       sda_b = 1'b1;
    logic       scl_in, scl_pull_low, bit_tick, byte_done, start_seen;
    logic [2:0] cnt_field;

    always #4 clk = ~clk;

    assign scl_in = ~scl_pull_low & ~ext_low;

    i2c_sclk_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_en   (master_en),
        .go          (go),
        .rate_code   (rate_code),
        .ack_en      (ack_en),
        .cnt_we      (cnt_we),
        .cnt_wdata   (cnt_wdata),
        .scl_in      (scl_in),
        .sda_in      (sda_b),
        .scl_pull_low(scl_pull_low),
        .bit_tick    (bit_tick),
        .byte_done   (byte_done),
        .start_seen  (start_seen),
        .cnt_field   (cnt_field)
    );

    typedef struct {
        int    kind;   // 1 pulled-low run, 0 released run, 2 end of byte
        int    val;
        string rq;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_fail = 0;
    int tick_all = 0, done_all = 0, start_all = 0;
    bit armed = 0, running = 0, got_done = 0;
    bit lvl;
    int run_len, highs, tick_m;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", rq, what, act, expv);
        end
    endtask

    task automatic emit(input int kind, input int val);
        exp_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R1", "unexpected scoreboard item", val, -1);
        end else begin
            e = exp_q.pop_front();
            chk(e.kind == kind && e.val == val, e.rq, "scoreboard item", val, e.val);
        end
    endtask

    // monitor: measures pulled-low and released runs of a master byte
    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_tick) tick_all++;
            if (byte_done) done_all++;
            if (start_seen) start_all++;
            if (armed && !running && scl_pull_low) begin
                running = 1;
                lvl     = 1'b1;
                run_len = 1;
                highs   = 0;
                tick_m  = 0;
            end else if (running) begin
                if (bit_tick) tick_m++;
                if (scl_pull_low == lvl) begin
                    run_len++;
                end else begin
                    emit(lvl ? 1 : 0, run_len);
                    if (!lvl) highs++;
                    lvl     = scl_pull_low;
                    run_len = 1;
                end
                if (byte_done) begin
                    emit(2, highs);
                    chk(tick_m == highs, "R7", "ticks per byte", tick_m, highs);
                    running  = 0;
                    armed    = 0;
                    got_done = 1;
                end
            end
        end
    end

    // driver: one master byte, expectations pushed before it runs
    task automatic master_byte(input int rate, input int bits, input bit ack,
                               input int k, input string rq_lo, input string rq_hi,
                               input string rq_end);
        int n, lo, hi, total;
        n     = (rate > 6) ? 6 : rate;
        lo    = 1 << (n + 4);
        hi    = lo + 8;
        total = ((bits == 0) ? 8 : bits) + int'(ack);
        master_en = 1'b0;
        repeat (4) @(negedge clk);
        rate_code = 3'(rate);
        ack_en    = ack;
        cnt_wdata = 3'(bits);
        cnt_we    = 1'b1;
        @(negedge clk);
        cnt_we    = 1'b0;
        master_en = 1'b1;
        @(negedge clk);
        for (int c = 0; c < total; c++) begin
            exp_q.push_back('{1, lo, rq_lo});
            exp_q.push_back('{0, hi + 3 + ((c == 0) ? k : 0), rq_hi});
        end
        exp_q.push_back('{2, total, rq_end});
        got_done = 0;
        armed    = 1;
        if (k > 0) ext_low = 1'b1;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        if (k > 0) begin
            do @(negedge clk); while (scl_pull_low);
            repeat (k) @(negedge clk);
            ext_low = 1'b0;
        end
        while (!got_done) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(scl_pull_low == 1'b1, "R7", "parked low after byte", int'(scl_pull_low), 1);
    endtask

    task automatic bus_start();
        ext_low = 1'b0;
        repeat (24) @(negedge clk);
        sda_b = 1'b0;
        repeat (24) @(negedge clk);
        ext_low = 1'b1;
        repeat (24) @(negedge clk);
        sda_b = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input int w);
        ext_low = 1'b0;
        repeat (w) @(negedge clk);
        ext_low = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic write_cnt(input int v);
        cnt_wdata = 3'(v);
        cnt_we    = 1'b1;
        @(negedge clk);
        cnt_we    = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_all();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_all();
    end

    initial begin
        int t0, d0, s0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(scl_pull_low == 1'b0, "R13", "reset line", int'(scl_pull_low), 0);
        chk(!bit_tick && !byte_done && !start_seen, "R13", "reset pulses",
            int'(bit_tick) + int'(byte_done) + int'(start_seen), 0);
        chk(cnt_field == 3'd0, "R13", "reset field", int'(cnt_field), 0);

        // R1 R2: master phases at every valid rate
        for (int r = 0; r < 7; r++) master_byte(r, 1, 1'b0, 0, "R1", "R2", "R7");
        // R3: invalid code behaves as code 6
        master_byte(7, 1, 1'b0, 0, "R3", "R3", "R3");
        // R5: field 0 gives eight clocks
        master_byte(0, 0, 1'b0, 0, "R1", "R2", "R5");
        // R6: acknowledge clock adds one
        master_byte(0, 3, 1'b1, 0, "R1", "R2", "R6");
        // R4: stretched first high phase
        master_byte(1, 2, 1'b0, 13, "R1", "R4", "R5");
        chk(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);

        // slave mode from here
        master_en = 1'b0;
        ack_en    = 1'b0;
        ext_low   = 1'b1;
        repeat (30) @(negedge clk);

        // R9: field holds a write, start clears it
        write_cnt(5);
        chk(cnt_field == 3'd5, "R9", "field after write", int'(cnt_field), 5);
        repeat (10) @(negedge clk);
        chk(cnt_field == 3'd5, "R9", "field held", int'(cnt_field), 5);
        // R8: SDA fall while SCL low is no start
        s0 = start_all;
        sda_b = 1'b0;
        repeat (24) @(negedge clk);
        sda_b = 1'b1;
        repeat (24) @(negedge clk);
        chk(start_all == s0, "R8", "no start with SCL low", start_all - s0, 0);
        chk(cnt_field == 3'd5, "R9", "field after non-start", int'(cnt_field), 5);
        bus_start();
        chk(start_all == s0 + 1, "R8", "start detected", start_all - s0, 1);
        chk(cnt_field == 3'd0, "R9", "field cleared by start", int'(cnt_field), 0);

        // R10: eight counted clocks
        t0 = tick_all;
        d0 = done_all;
        for (int i = 0; i < 7; i++) pulse(20);
        chk(done_all == d0, "R10", "no end before last clock", done_all - d0, 0);
        pulse(20);
        chk(tick_all == t0 + 8, "R10", "slave ticks", tick_all - t0, 8);
        chk(done_all == d0 + 1, "R10", "slave byte end", done_all - d0, 1);

        // R11: short glitch ignored
        t0 = tick_all;
        pulse(10);
        chk(tick_all == t0, "R11", "glitch ignored", tick_all - t0, 0);

        // R6 in slave mode: 3 data clocks + ack
        bus_start();
        write_cnt(3);
        ack_en = 1'b1;
        d0 = done_all;
        for (int i = 0; i < 3; i++) pulse(20);
        chk(done_all == d0, "R6", "ack clock awaited", done_all - d0, 0);
        pulse(20);
        chk(done_all == d0 + 1, "R6", "byte end after ack", done_all - d0, 1);

        // R10: without ack the next clock opens the next byte
        ack_en = 1'b0;
        bus_start();
        write_cnt(2);
        t0 = tick_all;
        d0 = done_all;
        pulse(20);
        pulse(20);
        chk(done_all == d0 + 1, "R10", "two-bit byte end", done_all - d0, 1);
        pulse(20);
        chk(tick_all == t0 + 3, "R10", "next byte clock counted", tick_all - t0, 3);
        chk(done_all == d0 + 1, "R10", "next byte not ended", done_all - d0, 1);
        pulse(20);
        chk(done_all == d0 + 2, "R10", "second byte end", done_all - d0, 2);

        // R12: start mid-byte restarts the count
        bus_start();
        d0 = done_all;
        for (int i = 0; i < 3; i++) pulse(20);
        bus_start();
        for (int i = 0; i < 5; i++) pulse(20);
        chk(done_all == d0, "R12", "count restarted", done_all - d0, 0);
        for (int i = 0; i < 3; i++) pulse(20);
        chk(done_all == d0 + 1, "R12", "byte end after restart", done_all - d0, 1);

        repeat (10) @(negedge clk);
        finish_all();
    end

endmodule